// File: doc/BRIEF.md
# 8-bit Compare Timer with Phase-Correct PWM

This block is an 8-bit counter with one compare register and one waveform output. Its count clock is picked by a select input. The choices are stopped, one of five taps of a shared 10-bit prescaler, or either edge of an external pin. The external pin passes through a two-flop synchronizer and an edge detector before it can advance the counter.

Three counting modes are offered:

- **Free-running:** the counter wraps from 0xFF to 0x00.
- **Clear-on-compare:** the compare value sets the period. The output pin toggles on each match, which makes a square-wave generator.
- **Phase-correct PWM:** the counter sweeps up and then down. The compare register is double-buffered so that a change cannot glitch the output.

Overflow and compare events set sticky flags. Each flag has its own mask bit, and the host clears a flag by writing a 1 to it. The host can read and write the counter and the compare register at any time.

Top module: `tc8_unit`

## Requirements
- R1: After reset the counter, compare readback, both flags, both interrupt outputs and the waveform output are all 0.
- R2: With `clk_sel` = 0 (stopped) the counter keeps its value.
- R3: `clk_sel` values 1, 2, 3, 4 and 5 advance the counter once every 1, 8, 64, 256 and 1024 clocks respectively.
- R4: `clk_sel` = 7 counts rising edges of `ext_pin` and 6 counts falling edges. If the pin changes before clock edge k, the counter changes at edge k+2. Edges of the other polarity are not counted.
- R5: In mode 0 (and mode 3) the counter increments by one per tick and wraps from 0xFF to 0x00. The overflow flag (`flags` bit 0) is set by a tick taken while the counter is 0xFF.
- R6: In mode 2, a tick taken while the counter equals the compare value loads 0 and sets the compare flag (`flags` bit 1). The period is therefore compare+1 ticks.
- R7: In mode 2, `wave_out` inverts on every compare match.
- R8: In mode 1 the counter runs 0 up to 0xFF and back down to 0, reversing at each end, with a period of 510 ticks. The overflow flag is set by a tick taken while the counter is 0.
- R9: In mode 1, a match on an upward tick drives `wave_out` to 0 and a match on a downward tick drives it to 1. A compare value of 0 therefore ends with the output low, and 0xFF ends with it high.
- R10: A compare write is visible on `cmp_q` in the next cycle. In mode 1 the value used for matching is taken from it only on a tick taken while the counter is 0xFF. In the other modes it is used at once.
- R11: A counter write takes effect at the next clock edge and overrides any tick in that cycle. It also suppresses the match on the first tick after it.
- R12: Writing 1 to a `flag_clr` bit clears that flag, but a flag set in the same cycle stays set. A flag stays set until cleared. `irq` bit n is flag n AND `irq_mask` bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 3 | Count clock select: 0 stop, 1..5 prescaler taps, 6 pin falling, 7 pin rising |
| mode | input | 2 | 0 free-running, 1 phase-correct PWM, 2 clear-on-compare, 3 as 0 |
| ext_pin | input | 1 | External count pin |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| flag_clr | input | 2 | Write-1-to-clear, bit 0 overflow, bit 1 compare |
| irq_mask | input | 2 | Interrupt mask per flag |
| cnt_q | output | 8 | Current counter value |
| cmp_q | output | 8 | Compare value last written |
| flags | output | 2 | Sticky flags, bit 0 overflow, bit 1 compare |
| irq | output | 2 | Masked interrupt requests |
| wave_out | output | 1 | Waveform output |

## Verification
The properties compare the counter and flags across one clock, using the controls sampled in the earlier cycle. They therefore assume that every host control is driven to a known value in each cycle after the internal reset releases. They also assume that the write strobe is the only way the counter is loaded out of sequence. The stimulus holds all controls at zero through reset and changes them only on falling clock edges. It widens every external pin pulse to two clocks, so that the synchronizer never drops an edge.

// File: rtl/tc8_pkg.sv
package tc8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_CTC  = 2'd2,
    MODE_ALT  = 2'd3
  } tc_mode_e;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_PIN_FALL = 3'd6,
    CS_PIN_RISE = 3'd7
  } clk_sel_e;

  localparam int unsigned NUM_TAPS = 5;
  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_CMP = 1;
  localparam int unsigned NUM_FLAGS = 2;

  // log2 of the division ratio for each prescaler tap
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tc8_prescale.sv
module tc8_prescale
  import tc8_pkg::*;
#(
  parameter int unsigned PRE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  output logic [NUM_TAPS-1:0] tap_tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run_en) begin
      pre_q <= pre_d;
    end
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned SH = tap_shift(i);
    if (SH == 0) begin : g_direct
      assign tap_tick[i] = run_en;
    end else begin : g_divided
      assign tap_tick[i] = run_en & (&pre_q[SH-1:0]);
    end
  end

endmodule

// File: rtl/tc8_pin_edge.sv
module tc8_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d[0] = pin_i;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= level;
    end
  end

  assign rise_o = level & ~last_q;
  assign fall_o = ~level & last_q;

endmodule

// File: rtl/tc8_flags.sv
module tc8_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic         flag_en;

  always_comb begin
    flag_en = |(set_i | clr_i);
    flag_d  = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;

endmodule

// File: rtl/tc8_count_core.sv
module tc8_count_core
  import tc8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  tc_mode_e         mode_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             wave_o,
  output logic             ovf_evt_o,
  output logic             cmp_evt_o
);

  localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             down_q, down_d;
  logic             blk_q, blk_d;
  logic             wave_q, wave_d;

  logic             at_top, at_bot, pwm, ctc;
  logic             down_eff, take, hit;
  logic             cnt_en, buf_en, act_en;

  always_comb begin
    at_top   = (cnt_q == TOPV);
    at_bot   = (cnt_q == '0);
    pwm      = (mode_i == MODE_PWM);
    ctc      = (mode_i == MODE_CTC);
    down_eff = at_top ? 1'b1 : (at_bot ? 1'b0 : down_q);
    take     = tick_i & ~cnt_wr_i;
    hit      = take & ~blk_q & (cnt_q == act_q);
  end

  assign ovf_evt_o = take & (pwm ? at_bot : at_top);
  assign cmp_evt_o = hit;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    blk_d  = blk_q;
    wave_d = wave_q;
    buf_d  = cmp_wr_i ? cmp_wdata_i : buf_q;
    act_d  = act_q;

    if (!pwm) begin
      act_d = buf_d;
    end else if (take && at_top) begin
      act_d = buf_q;
    end

    if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
      blk_d = 1'b1;
    end else if (tick_i) begin
      blk_d = 1'b0;
      if (pwm) begin
        cnt_d  = down_eff ? (cnt_q - ONE) : (cnt_q + ONE);
        down_d = down_eff;
        if (hit) begin
          wave_d = down_eff;
        end
      end else if (ctc) begin
        cnt_d = hit ? '0 : (cnt_q + ONE);
        if (hit) begin
          wave_d = ~wave_q;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  // clock enables
  always_comb begin
    cnt_en = cnt_wr_i | tick_i;
    buf_en = cmp_wr_i;
    act_en = ~pwm | (take & at_top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      blk_q  <= 1'b0;
      wave_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      blk_q  <= blk_d;
      wave_q <= wave_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = buf_q;
  assign wave_o = wave_q;

endmodule

// File: rtl/tc8_unit.sv
module tc8_unit
  import tc8_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           clk_sel,
  input  logic [1:0]           mode,
  input  logic                 ext_pin,
  input  logic                 cnt_wr,
  input  logic [CNT_W-1:0]     cnt_wdata,
  input  logic                 cmp_wr,
  input  logic [CNT_W-1:0]     cmp_wdata,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_mask,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [CNT_W-1:0]     cmp_q,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] irq,
  output logic                 wave_out
);

  logic [1:0]          rs_q;
  logic                rst_sn;
  logic [NUM_TAPS-1:0] taps;
  logic                pin_rise, pin_fall;
  logic                pre_run, tick;
  logic                ovf_evt, cmp_evt;
  logic [NUM_FLAGS-1:0] set_vec;
  clk_sel_e            sel;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sn = rs_q[1];

  assign sel     = clk_sel_e'(clk_sel);
  assign pre_run = (clk_sel >= 3'd1) && (clk_sel <= 3'(NUM_TAPS));

  tc8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_en   (pre_run),
    .tap_tick (taps)
  );

  tc8_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .rst_n  (rst_sn),
    .pin_i  (ext_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    case (sel)
      CS_DIV1:     tick = taps[0];
      CS_DIV8:     tick = taps[1];
      CS_DIV64:    tick = taps[2];
      CS_DIV256:   tick = taps[3];
      CS_DIV1024:  tick = taps[4];
      CS_PIN_FALL: tick = pin_fall;
      CS_PIN_RISE: tick = pin_rise;
      default:     tick = 1'b0;
    endcase
  end

  tc8_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sn),
    .tick_i      (tick),
    .mode_i      (tc_mode_e'(mode)),
    .cnt_wr_i    (cnt_wr),
    .cnt_wdata_i (cnt_wdata),
    .cmp_wr_i    (cmp_wr),
    .cmp_wdata_i (cmp_wdata),
    .cnt_o       (cnt_q),
    .cmp_o       (cmp_q),
    .wave_o      (wave_out),
    .ovf_evt_o   (ovf_evt),
    .cmp_evt_o   (cmp_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_OVF] = ovf_evt;
    set_vec[FLAG_CMP] = cmp_evt;
  end

  tc8_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sn),
    .set_i  (set_vec),
    .clr_i  (flag_clr),
    .mask_i (irq_mask),
    .flag_o (flags),
    .irq_o  (irq)
  );

endmodule

// File: rtl/tc8_unit_chk.sv
module tc8_unit_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic [1:0]       mode,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             cmp_wr,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic [1:0]       flag_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic [1:0]       flags
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  // R5
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));

  // R8
  pwm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE
                                   || cnt_q == $past(cnt_q) - ONE));

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));

  // R10
  cmp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp_q == $past(cmp_wdata)));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

  // R12
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flag_clr[1]) |=> flags[1]);

endmodule

bind tc8_unit tc8_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .clk_sel   (clk_sel),
  .mode      (mode),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .cmp_wr    (cmp_wr),
  .cmp_wdata (cmp_wdata),
  .flag_clr  (flag_clr),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .flags     (flags)
);

// File: tb/sim_tc8_unit.sv
module sim_tc8_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic [1:0] mode;
  logic       ext_pin;
  logic       cnt_wr;
  logic [7:0] cnt_wdata;
  logic       cmp_wr;
  logic [7:0] cmp_wdata;
  logic [1:0] flag_clr;
  logic [1:0] irq_mask;
  logic [7:0] cnt_q;
  logic [7:0] cmp_q;
  logic [1:0] flags;
  logic [1:0] irq;
  logic       wave_out;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  tc8_unit u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode), .ext_pin(ext_pin),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .irq_mask(irq_mask), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .flags(flags), .irq(irq), .wave_out(wave_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcnt(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic wcmp(input logic [7:0] v);
    cmp_wr = 1'b1; cmp_wdata = v;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic clrf(input logic [1:0] b);
    flag_clr = b;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] e, act, bufv, p;
    logic       w, dn, blk, mo, mc, hit, eff;
    int         n;
    int         divs[5] = '{1, 8, 64, 256, 1024};
    logic [7:0] ctc_vals[5] = '{8'd3, 8'd0, 8'd17, 8'd200, 8'd255};
    logic [7:0] pwm_vals[4] = '{8'h40, 8'h00, 8'hFF, 8'h80};

    rst_n = 1'b0; clk_sel = 3'd0; mode = 2'd0; ext_pin = 1'b0;
    cnt_wr = 1'b0; cnt_wdata = 8'd0; cmp_wr = 1'b0; cmp_wdata = 8'd0;
    flag_clr = 2'b00; irq_mask = 2'b00;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    check(cnt_q == 8'd0, "R1 counter", cnt_q, 0);
    check(cmp_q == 8'd0, "R1 compare", cmp_q, 0);
    check(flags == 2'b00, "R1 flags", flags, 0);
    check(irq == 2'b00, "R1 irq", irq, 0);
    check(wave_out == 1'b0, "R1 wave", wave_out, 0);

    // R2 stopped clock holds counter
    wcnt(8'd5);
    cyc(50);
    check(cnt_q == 8'd5, "R2 stopped hold", cnt_q, 5);

    // R3 prescaler taps
    for (int i = 0; i < 5; i++) begin
      clk_sel = 3'd0;
      wcnt(8'd0);
      clk_sel = 3'(i + 1);
      p = cnt_q; n = 0;
      while (cnt_q == p && n < 3000) begin @(negedge clk); n++; end
      p = cnt_q; n = 0;
      do begin @(negedge clk); n++; end while (cnt_q == p && n < 3000);
      check(n == divs[i], "R3 tap interval", n, divs[i]);
    end

    // R4 external pin, rising then falling
    clk_sel = 3'd0;
    cyc(3);
    wcnt(8'd0);
    clk_sel = 3'd7;
    cyc(2);
    ext_pin = 1'b1;
    cyc(2);
    check(cnt_q == 8'd0, "R4 sync latency early", cnt_q, 0);
    cyc(1);
    check(cnt_q == 8'd1, "R4 sync latency", cnt_q, 1);
    ext_pin = 1'b0;
    cyc(4);
    check(cnt_q == 8'd1, "R4 falling ignored", cnt_q, 1);
    for (int k = 0; k < 10; k++) begin
      ext_pin = 1'b1; cyc(2); ext_pin = 1'b0; cyc(2);
    end
    cyc(3);
    check(cnt_q == 8'd11, "R4 rising count", cnt_q, 11);
    clk_sel = 3'd6;
    for (int k = 0; k < 8; k++) begin
      ext_pin = 1'b1; cyc(2); ext_pin = 1'b0; cyc(2);
    end
    cyc(3);
    check(cnt_q == 8'd19, "R4 falling count", cnt_q, 19);

    // R5 free-running wrap and overflow
    clk_sel = 3'd0;
    mode = 2'd0;
    wcnt(8'hF0);
    clrf(2'b11);
    check(flags[0] == 1'b0, "R12 flag cleared", flags[0], 0);
    e = 8'hF0;
    clk_sel = 3'd1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      e = e + 8'd1;
      check(cnt_q == e, "R5 count step", cnt_q, e);
    end
    check(flags[0] == 1'b1, "R5 overflow flag", flags[0], 1);
    check(irq[0] == 1'b0, "R12 masked irq", irq[0], 0);
    irq_mask = 2'b01;
    #1;
    check(irq[0] == 1'b1, "R12 unmasked irq", irq[0], 1);
    clk_sel = 3'd0;
    clrf(2'b01);
    check(flags[0] == 1'b0, "R12 clear by write", flags[0], 0);
    check(irq[0] == 1'b0, "R12 irq after clear", irq[0], 0);

    // R12 set beats clear in the same cycle
    wcnt(8'hFE);
    clk_sel = 3'd1;
    @(negedge clk);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    check(flags[0] == 1'b1, "R12 set wins", flags[0], 1);
    clk_sel = 3'd0;
    irq_mask = 2'b00;

    // R6 / R7 clear-on-compare sweep
    for (int j = 0; j < 5; j++) begin
      clk_sel = 3'd0;
      mode = 2'd2;
      wcmp(ctc_vals[j]);
      wcnt(8'd0);
      clrf(2'b11);
      e = 8'd0; blk = 1'b1; w = wave_out; mc = 1'b0;
      clk_sel = 3'd1;
      for (int i = 0; i < 3 * (int'(ctc_vals[j]) + 1) + 260; i++) begin
        @(negedge clk);
        if (!blk && e == ctc_vals[j]) begin
          e = 8'd0; w = ~w; mc = 1'b1;
        end else begin
          e = e + 8'd1;
        end
        blk = 1'b0;
        check(cnt_q == e, "R6 ctc count", cnt_q, e);
        check(wave_out == w, "R7 toggle", wave_out, w);
        check(flags[1] == mc, "R6 compare flag", flags[1], mc);
      end
    end

    // R11 counter write blocks next match
    clk_sel = 3'd0;
    wcmp(8'd10);
    clk_sel = 3'd1;
    cyc(5);
    cnt_wr = 1'b1; cnt_wdata = 8'd10; flag_clr = 2'b11;
    @(negedge clk);
    cnt_wr = 1'b0; flag_clr = 2'b00;
    check(cnt_q == 8'd10, "R11 load", cnt_q, 10);
    @(negedge clk);
    check(cnt_q == 8'd11, "R11 blocked match count", cnt_q, 11);
    check(flags[1] == 1'b0, "R11 blocked match flag", flags[1], 0);

    // R8 / R9 / R10 phase-correct PWM sweep
    for (int j = 0; j < 4; j++) begin
      clk_sel = 3'd0;
      mode = 2'd0;
      wcmp(pwm_vals[j]);
      mode = 2'd1;
      wcnt(8'd0);
      clrf(2'b11);
      act = pwm_vals[j]; bufv = pwm_vals[j];
      e = 8'd0; dn = 1'b0; blk = 1'b1; w = wave_out; mo = 1'b0;
      clk_sel = 3'd1;
      for (int i = 0; i < 1100; i++) begin
        if (j == 0 && i == 300) begin
          cmp_wr = 1'b1; cmp_wdata = 8'h20;
        end else begin
          cmp_wr = 1'b0;
        end
        @(negedge clk);
        eff = (e == 8'hFF) ? 1'b1 : ((e == 8'h00) ? 1'b0 : dn);
        hit = !blk && (e == act);
        if (e == 8'h00) mo = 1'b1;
        if (hit) w = eff;
        if (e == 8'hFF) act = bufv;
        e = eff ? (e - 8'd1) : (e + 8'd1);
        dn = eff; blk = 1'b0;
        if (j == 0 && i == 300) bufv = 8'h20;
        check(cnt_q == e, "R8 pwm count", cnt_q, e);
        check(wave_out == w, "R9 pwm output", wave_out, w);
        check(flags[0] == mo, "R8 bottom flag", flags[0], mo);
        check(cmp_q == bufv, "R10 compare readback", cmp_q, bufv);
      end
      cmp_wr = 1'b0;
      if (pwm_vals[j] == 8'h00) check(wave_out == 1'b0, "R9 zero stays low", wave_out, 0);
      if (pwm_vals[j] == 8'hFF) check(wave_out == 1'b1, "R9 full stays high", wave_out, 1);
    end

    clk_sel = 3'd0;
    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule